// File: doc/BRIEF.md
# Floating-Point Condition Predicate Evaluator

This block decides whether a floating-point conditional test is true. It takes a 6-bit predicate code and the four condition-code bits held in the floating-point status register (negative, zero, infinity and not-a-number) and produces a single true/false result. Predicates come in two groups. One group is aware of unordered operands. The other group is signalling: when the operand was a NaN, it raises the branch-on-unordered exception. Predicate codes outside the defined range are reported as illegal.

For the conditional-branch form of the instruction, the block also computes the next-PC offset from the start of the instruction. It accepts a 16-bit or a 32-bit displacement. The exception byte of the status register is treated as cleared at the start of each evaluation. If the branch-on-unordered exception is raised and its enable bit is set in the trap-enable byte, the block signals a trap instead of a branch. The evaluation is combinational. The results are captured on a valid strobe and presented one cycle later.

Top module: `fp_cond_eval`

## Requirements
- R1: While reset is held and after it is released, before any request, res_valid, cond_true, bsun_set, illegal, trap and next_off are all zero.
- R2: A request with req_valid high in one cycle produces res_valid high in the following cycle only. cond_true, illegal and next_off keep their values in cycles without a request.
- R3: A predicate value of 0x20 or above gives illegal=1, cond_true=0, bsun_set=0, trap=0 and next_off=0.
- R4: With predicate bits 5:3 zero, the low three bits select a base relation over the condition bits N=cc[3], Z=cc[2], NAN=cc[0]. The relations are: 0 always false; 1 Z; 2 !NAN&!Z&!N; 3 Z|(!NAN&!N); 4 N&!NAN&!Z; 5 Z|(N&!NAN); 6 !NAN&!Z; 7 !NAN.
- R5: When predicate bit 3 is set, the base relation selected by (low nibble XOR 0xF) is evaluated and the result is inverted. For example, 0x0F is always true and 0x0E is "not equal".
- R6: When predicate bit 4 is set, the test uses the same relation as the low 4 bits. bsun_set pulses with res_valid when NAN is set. A predicate with bit 4 clear never raises bsun_set.
- R7: The infinity condition bit cc[1] has no effect on any output.
- R8: In the short form (long_form=0), a true condition gives next_off = sign-extended disp_w0 + 2.
- R9: In the long form (long_form=1), a true condition gives next_off = {disp_w0, disp_w1} + 2, with disp_w0 as the upper half.
- R10: A false condition gives next_off = 4 in the short form and 6 in the long form.
- R11: The branch-on-unordered exception sits at bit 7 of the exception byte. trap=1 exactly when bsun_set occurs and trap_en[7] is 1, and next_off is then 0. trap_en bits 6:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Capture strobe for an evaluation |
| pred | input | 6 | Predicate code |
| cc | input | 4 | Condition bits {N, Z, I, NAN} |
| disp_w0 | input | 16 | First displacement word (short displacement, or upper half of the long one) |
| disp_w1 | input | 16 | Second displacement word (lower half of the long displacement) |
| long_form | input | 1 | Selects the 32-bit displacement form |
| trap_en | input | 8 | Exception trap-enable byte |
| res_valid | output | 1 | Result valid, one cycle after req_valid |
| cond_true | output | 1 | Predicate result |
| next_off | output | 32 | Next-PC offset from the instruction start |
| bsun_set | output | 1 | Branch-on-unordered exception pulse |
| illegal | output | 1 | Predicate code out of range |
| trap | output | 1 | Enabled exception, taken instead of the branch |

## Verification
All sixteen combinations of the condition bits are applied under every aware predicate and every signalling predicate. This separates each base relation from its inverted partner, and separates the signalling group from the aware group through bsun_set. The sweep is repeated with the infinity bit toggled to show that this bit is ignored. Displacements with the top bit set and clear, in both the short and the long form, separate correct sign extension and correct word order from the not-taken step sizes. Out-of-range predicates and the different trap-enable patterns separate the illegal, trap and plain-branch outcomes.

// File: rtl/fp_cond_pkg.sv
package fp_cond_pkg;
  localparam int CC_NAN   = 0;
  localparam int CC_INF   = 1;
  localparam int CC_ZERO  = 2;
  localparam int CC_NEG   = 3;
  localparam int EXC_W    = 8;
  localparam int BSUN_BIT = 7;

  typedef enum logic [2:0] {
    REL_FALSE = 3'd0,
    REL_EQ    = 3'd1,
    REL_GT    = 3'd2,
    REL_GE    = 3'd3,
    REL_LT    = 3'd4,
    REL_LE    = 3'd5,
    REL_GL    = 3'd6,
    REL_GLE   = 3'd7
  } rel_e;

  typedef struct packed {
    logic illegal;
    logic signalling;
    logic invert;
    rel_e rel;
  } pred_dec_t;
endpackage

// File: rtl/fp_pred_decode.sv
module fp_pred_decode
  import fp_cond_pkg::*;
#(
  parameter int PRED_W = 6
) (
  input  logic [PRED_W-1:0] pred,
  output pred_dec_t         dec
);
  localparam int NIB_W = 4;

  logic [NIB_W-1:0] nib;

  always_comb begin
    nib            = pred[3] ? (pred[NIB_W-1:0] ^ 4'hF) : pred[NIB_W-1:0];
    dec.illegal    = |pred[PRED_W-1:5];
    dec.signalling = pred[4];
    dec.invert     = pred[3];
    dec.rel        = rel_e'(nib[2:0]);
  end
endmodule

// File: rtl/fp_rel_eval.sv
module fp_rel_eval
  import fp_cond_pkg::*;
(
  input  rel_e       rel,
  input  logic [3:0] cc,
  output logic       base
);
  logic n, z, un;

  always_comb begin
    n  = cc[CC_NEG];
    z  = cc[CC_ZERO];
    un = cc[CC_NAN];
    unique case (rel)
      REL_FALSE: base = 1'b0;
      REL_EQ:    base = z;
      REL_GT:    base = !un && !z && !n;
      REL_GE:    base = z || (!un && !n);
      REL_LT:    base = n && !un && !z;
      REL_LE:    base = z || (n && !un);
      REL_GL:    base = !un && !z;
      REL_GLE:   base = !un;
      default:   base = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_branch_offset.sv
module fp_branch_offset #(
  parameter int DISP_W = 16
) (
  input  logic [DISP_W-1:0]   w0,
  input  logic [DISP_W-1:0]   w1,
  input  logic                long_form,
  input  logic                taken,
  output logic [2*DISP_W-1:0] off
);
  localparam int OFF_W = 2 * DISP_W;
  localparam logic [OFF_W-1:0] STEP_SHORT = OFF_W'(4);
  localparam logic [OFF_W-1:0] STEP_LONG  = OFF_W'(6);
  localparam logic [OFF_W-1:0] TAKEN_ADJ  = OFF_W'(2);

  logic [OFF_W-1:0] disp;

  always_comb begin
    if (long_form) disp = {w0, w1};
    else           disp = {{(OFF_W-DISP_W){w0[DISP_W-1]}}, w0};
    if (taken)          off = disp + TAKEN_ADJ;
    else if (long_form) off = STEP_LONG;
    else                off = STEP_SHORT;
  end
endmodule

// File: rtl/fp_cond_eval.sv
module fp_cond_eval
  import fp_cond_pkg::*;
#(
  parameter int PRED_W = 6,
  parameter int DISP_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [PRED_W-1:0]   pred,
  input  logic [3:0]          cc,
  input  logic [DISP_W-1:0]   disp_w0,
  input  logic [DISP_W-1:0]   disp_w1,
  input  logic                long_form,
  input  logic [EXC_W-1:0]    trap_en,
  output logic                res_valid,
  output logic                cond_true,
  output logic [2*DISP_W-1:0] next_off,
  output logic                bsun_set,
  output logic                illegal,
  output logic                trap
);
  localparam int OFF_W = 2 * DISP_W;

  pred_dec_t        dec;
  logic             base;
  logic             cond_d, bsun_d, trap_d;
  logic [EXC_W-1:0] exc_d;
  logic [OFF_W-1:0] off_raw, off_d;

  fp_pred_decode #(.PRED_W(PRED_W)) u_dec (.pred(pred), .dec(dec));

  fp_rel_eval u_rel (.rel(dec.rel), .cc(cc), .base(base));

  fp_branch_offset #(.DISP_W(DISP_W)) u_off (
    .w0(disp_w0), .w1(disp_w1), .long_form(long_form),
    .taken(cond_d), .off(off_raw)
  );

  always_comb begin
    cond_d = !dec.illegal && (base ^ dec.invert);
    bsun_d = !dec.illegal && dec.signalling && cc[CC_NAN];
    exc_d  = '0;
    exc_d[BSUN_BIT] = bsun_d;
    trap_d = |(exc_d & trap_en);
    off_d  = (dec.illegal || trap_d) ? '0 : off_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      bsun_set  <= 1'b0;
      trap      <= 1'b0;
      cond_true <= 1'b0;
      illegal   <= 1'b0;
      next_off  <= '0;
    end else begin
      res_valid <= req_valid;
      bsun_set  <= req_valid && bsun_d;
      trap      <= req_valid && trap_d;
      if (req_valid) begin
        cond_true <= cond_d;
        illegal   <= dec.illegal;
        next_off  <= off_d;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(cond_true) && $stable(next_off))); // R2
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && illegal) |-> (!cond_true && !bsun_set && !trap && next_off == '0)); // R3
  AST_BSUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bsun_set |-> res_valid); // R6
  AST_TRAP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (bsun_set && next_off == '0)); // R11
  AST_NOT_TAKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cond_d && !dec.illegal && !trap_d) |=>
      (next_off == (long_form ? OFF_W'(6) : OFF_W'(4)))); // R10
endmodule

// File: tb/fp_cond_eval_tb_top.sv
module fp_cond_eval_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [5:0]  pred;
  logic [3:0]  cc;
  logic [15:0] disp_w0, disp_w1;
  logic        long_form;
  logic [7:0]  trap_en;
  logic        res_valid, cond_true, bsun_set, illegal, trap;
  logic [31:0] next_off;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp_cond_eval dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pred(pred), .cc(cc),
    .disp_w0(disp_w0), .disp_w1(disp_w1), .long_form(long_form),
    .trap_en(trap_en), .res_valid(res_valid), .cond_true(cond_true),
    .next_off(next_off), .bsun_set(bsun_set), .illegal(illegal), .trap(trap)
  );

  function automatic logic rel_ref(input int r, input logic [3:0] c);
    logic n, z, u;
    n = c[3]; z = c[2]; u = c[0];
    case (r)
      0: return 1'b0;
      1: return z;
      2: return !u && !z && !n;
      3: return z || (!u && !n);
      4: return n && !u && !z;
      5: return z || (n && !u);
      6: return !u && !z;
      default: return !u;
    endcase
  endfunction

  function automatic logic pred_ref(input logic [5:0] p, input logic [3:0] c);
    int lo;
    lo = int'(p[3:0]);
    if (p >= 6'h20) return 1'b0;
    if (lo >= 8) return !rel_ref(15 - lo, c);
    return rel_ref(lo, c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] p, input logic [3:0] c, input logic [15:0] a,
                       input logic [15:0] b, input logic lf, input logic [7:0] te);
    @(negedge clk);
    pred = p; cc = c; disp_w0 = a; disp_w1 = b; long_form = lf; trap_en = te;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; pred = '0; cc = '0; disp_w0 = '0;
    disp_w1 = '0; long_form = 1'b0; trap_en = '0;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outs", {27'd0, res_valid, cond_true, bsun_set, illegal, trap}, 32'd0);
    check("R1 off", next_off, 32'd0);
  endtask

  task automatic t_aware_sweep;
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 16; c++) begin
        apply(6'(p), 4'(c), 16'h0010, 16'h0, 1'b0, 8'h00);
        check(p < 8 ? "R4 relation" : "R5 inverted", {31'd0, cond_true},
              {31'd0, pred_ref(6'(p), 4'(c))});
        check("R6 aware no bsun", {31'd0, bsun_set}, 32'd0);
        check("R2 valid", {31'd0, res_valid}, 32'd1);
      end
    end
  endtask

  task automatic t_signalling_sweep;
    for (int p = 16; p < 32; p++) begin
      for (int c = 0; c < 16; c++) begin
        apply(6'(p), 4'(c), 16'h0010, 16'h0, 1'b0, 8'h00);
        check("R6 relation", {31'd0, cond_true}, {31'd0, pred_ref(6'(p), 4'(c))});
        check("R6 bsun", {31'd0, bsun_set}, {31'd0, c[0]});
      end
    end
  endtask

  task automatic t_inf_ignored;
    for (int p = 0; p < 32; p++) begin
      for (int c = 0; c < 16; c += 2) begin
        apply(6'(p), 4'(c | 2), 16'h0020, 16'h0, 1'b0, 8'h80);
        check("R7 inf ignored", {31'd0, cond_true}, {31'd0, pred_ref(6'(p), 4'(c))});
      end
    end
  endtask

  task automatic t_hold;
    apply(6'h0F, 4'h0, 16'h0100, 16'h0, 1'b0, 8'h00);
    @(negedge clk);
    check("R2 valid drops", {31'd0, res_valid}, 32'd0);
    check("R2 hold cond", {31'd0, cond_true}, 32'd1);
    check("R2 hold off", next_off, 32'h102);
  endtask

  task automatic t_illegal;
    for (int p = 32; p < 64; p += 7) begin
      apply(6'(p), 4'h1, 16'h0040, 16'h0, 1'b1, 8'hFF);
      check("R3 illegal", {31'd0, illegal}, 32'd1);
      check("R3 cond", {29'd0, cond_true, bsun_set, trap}, 32'd0);
      check("R3 off", next_off, 32'd0);
    end
    apply(6'h1F, 4'h0, 16'h0040, 16'h0, 1'b0, 8'h00);
    check("R3 legal edge", {31'd0, illegal}, 32'd0);
  endtask

  task automatic t_branch;
    apply(6'h0F, 4'h0, 16'h1234, 16'hBEEF, 1'b0, 8'h00);
    check("R8 short pos", next_off, 32'h0000_1236);
    apply(6'h0F, 4'h0, 16'hFFF0, 16'h0000, 1'b0, 8'h00);
    check("R8 short neg", next_off, 32'hFFFF_FFF2);
    apply(6'h0F, 4'h0, 16'h0001, 16'h8000, 1'b1, 8'h00);
    check("R9 long", next_off, 32'h0001_8002);
    apply(6'h0F, 4'h0, 16'hFFFF, 16'hFFF0, 1'b1, 8'h00);
    check("R9 long neg", next_off, 32'hFFFF_FFF2);
    apply(6'h00, 4'h0, 16'h1234, 16'h5678, 1'b0, 8'h00);
    check("R10 short step", next_off, 32'd4);
    apply(6'h00, 4'h0, 16'h1234, 16'h5678, 1'b1, 8'h00);
    check("R10 long step", next_off, 32'd6);
  endtask

  task automatic t_trap;
    apply(6'h1F, 4'h1, 16'h0100, 16'h0, 1'b0, 8'h80);
    check("R11 trap", {30'd0, trap, bsun_set}, 32'd3);
    check("R11 trap off", next_off, 32'd0);
    apply(6'h1F, 4'h1, 16'h0100, 16'h0, 1'b0, 8'h7F);
    check("R11 low enables ignored", {30'd0, trap, bsun_set}, 32'd1);
    check("R11 branch kept", next_off, 32'h102);
    apply(6'h0F, 4'h1, 16'h0100, 16'h0, 1'b0, 8'hFF);
    check("R11 no trap aware", {31'd0, trap}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_aware_sweep();
    t_signalling_sweep();
    t_inf_ignored();
    t_hold();
    t_illegal();
    t_branch();
    t_trap();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule